// File: doc/BRIEF.md
# SDRAM Command Decoder and Legality Checker

This block watches the command pins of a single-data-rate synchronous DRAM from the memory side. On every rising clock edge it samples chip select, the three strobe lines, clock enable, the byte masks, the bank select and the address. It turns them into one command code and tracks which of the four banks hold an open row. It also follows the low-power states (clock suspend, power down, self refresh) that clock-enable transitions select. Every result is registered, so each output shows the verdict on the edge just past.

Illegal commands are flagged and not executed. These are a column access to a closed bank, an activate to an open bank, refresh or mode programming with rows open, the reserved encoding, and anything other than a no-operation or deselect in the first cycle after leaving a low-power state. A write-beat byte enable applies the masks with no delay. A read output enable applies them two clocks later. The mode-programming command stores the address field as an opcode.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With `cs_n` high the code is DESEL (0). With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decodes as follows: 111 NOP (1), 011 ACT (2), 101 RD (3), or RDA (4) when `addr[10]`=1, 100 WR (5), or WRA (6) when `addr[10]`=1, 010 PRE (7), or PREA (8) when `addr[10]`=1, 001 REF (9), 000 MRS (11), 110 reserved (12). Code 10 is self-refresh entry and 13 is a frozen cycle. `cmd_code_o` shows the code of the edge just sampled.
- R2: The bank number is {`ba[1]`,`ba[0]`}, so `ba[0]` alone selects bank 1 and `ba[1]` alone selects bank 2. A legal ACT sets `bank_active_o[bank]`.
- R3: A legal PRE closes only the selected bank. PREA closes every bank. A legal RDA or WRA closes its bank on the same edge.
- R4: ACT to an open bank, RD/RDA/WR/WRA to a closed bank, and the reserved encoding each set `cmd_illegal_o` and change no bank.
- R5: REF and MRS are legal only when no bank is open. A legal MRS loads `addr` into `mode_opcode_o`.
- R6: The refresh encoding on an edge where `cke` is low while in run mode (run mode implies `cke` was high before) reports SREF (10). If all banks are closed, `mode_o` becomes SELF (3). Otherwise the flag is raised.
- R7: In run mode (0), a low `cke` that is not a self-refresh entry leads to SUSPEND (1) if a burst is in progress or a bank is open, and to PDOWN (2) otherwise. `mode_o` changes after that edge.
- R8: In any low-power mode, a high `cke` returns `mode_o` to RUN after that edge. That edge reports FROZEN (13).
- R9: On the first edge after that return, any command other than NOP or DESEL raises the flag and is not executed.
- R10: On edges outside run mode, and on the entry edge itself, no command executes, banks and `rd_oe_o` hold, `wr_be_o` is zero and the flag stays low except as R6 says.
- R11: A legal RD/WR starts a burst of BURST_LEN (default 4) beats on consecutive running edges. On write beats `wr_be_o` equals `~dqm` of that same edge. Otherwise it is zero.
- R12: A read beat at running edge k gives `rd_oe_o` = `~dqm` sampled at k, visible after running edge k+1. A non-read edge k gives zero.
- R13: While `rst` is high all banks are closed, the mode is RUN, the code is NOP, and the flag, enables and opcode are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| dqm | input | DQM_W | Byte masks |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Address / opcode |
| cmd_code_o | output | 4 | Decoded command code |
| cmd_illegal_o | output | 1 | Illegal command seen |
| bank_active_o | output | 2**BA_W | Per-bank open-row flags |
| mode_o | output | 2 | RUN, SUSPEND, PDOWN, SELF |
| rd_oe_o | output | DQM_W | Read output enable after mask latency |
| wr_be_o | output | DQM_W | Write byte enable |
| mode_opcode_o | output | ADDR_W | Last programmed opcode |

## Verification
The bench targets the cycle right after `cke` returns high. A design that executed an activate there would open a bank and miss the flag. It drops `cke` while a read burst runs on an auto-precharged bank whose bank flags are already clear, where a design that looked only at banks would wrongly enter power down. It changes `dqm` beat by beat inside bursts to separate the zero-cycle write mask from the two-cycle read mask; a swapped latency misaligns every enable. It holds low-power states with garbage commands, so a decoder that is not frozen would move bank flags or the read enable.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL  = 4'd0,
    CMD_NOP    = 4'd1,
    CMD_ACT    = 4'd2,
    CMD_RD     = 4'd3,
    CMD_RDA    = 4'd4,
    CMD_WR     = 4'd5,
    CMD_WRA    = 4'd6,
    CMD_PRE    = 4'd7,
    CMD_PREA   = 4'd8,
    CMD_REF    = 4'd9,
    CMD_SREF   = 4'd10,
    CMD_MRS    = 4'd11,
    CMD_RSVD   = 4'd12,
    CMD_FROZEN = 4'd13
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_SUSPEND = 2'd1,
    MODE_PDOWN   = 2'd2,
    MODE_SELF    = 2'd3
  } mode_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ap,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = ap ? CMD_RDA : CMD_RD;
        3'b100:  cmd = ap ? CMD_WRA : CMD_WR;
        3'b010:  cmd = ap ? CMD_PREA : CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_RSVD;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int BA_W = 2,
  localparam int NUM_BANKS = 1 << BA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 exec,
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      ba,
  output logic [NUM_BANKS-1:0] active
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic open_q;
    logic hit;
    assign hit = (ba == BA_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        open_q <= 1'b0;
      end else if (exec) begin
        case (cmd)
          CMD_ACT:                  if (hit) open_q <= 1'b1;
          CMD_PRE, CMD_RDA, CMD_WRA: if (hit) open_q <= 1'b0;
          CMD_PREA:                 open_q <= 1'b0;
          default:                  open_q <= open_q;
        endcase
      end
    end
    assign active[i] = open_q;
  end
endmodule

// File: rtl/sdram_dq_enables.sv
module sdram_dq_enables #(
  parameter int DQM_W     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             start,
  input  logic             start_wr,
  input  logic [DQM_W-1:0] dqm,
  output logic [DQM_W-1:0] rd_oe,
  output logic [DQM_W-1:0] wr_be,
  output logic             busy
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic             stg_beat_q;
  logic [DQM_W-1:0] stg_dqm_q;
  logic             beat;
  logic             beat_wr;

  assign busy    = (cnt_q != '0);
  assign beat    = start || busy;
  assign beat_wr = start ? start_wr : wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      wr_q       <= 1'b0;
      stg_beat_q <= 1'b0;
      stg_dqm_q  <= '0;
      rd_oe      <= '0;
      wr_be      <= '0;
    end else if (run) begin
      cnt_q      <= start ? LOAD : (busy ? cnt_q - CNT_W'(1) : '0);
      wr_q       <= beat_wr;
      wr_be      <= (beat && beat_wr) ? ~dqm : '0;
      stg_beat_q <= beat && !beat_wr;
      stg_dqm_q  <= dqm;
      rd_oe      <= stg_beat_q ? ~stg_dqm_q : '0;
    end else begin
      wr_be      <= '0;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int DQM_W     = 2,
  parameter int BURST_LEN = 4,
  parameter int AP_BIT    = 10,
  localparam int NUM_BANKS = 1 << BA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [DQM_W-1:0]     dqm,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic [3:0]           cmd_code_o,
  output logic                 cmd_illegal_o,
  output logic [NUM_BANKS-1:0] bank_active_o,
  output logic [1:0]           mode_o,
  output logic [DQM_W-1:0]     rd_oe_o,
  output logic [DQM_W-1:0]     wr_be_o,
  output logic [ADDR_W-1:0]    mode_opcode_o
);
  cmd_e                 raw_cmd;
  cmd_e                 code_d, code_q;
  mode_e                mode_d, mode_q;
  logic                 guard_q;
  logic                 ill_d, ill_q;
  logic [NUM_BANKS-1:0] bank_q;
  logic [ADDR_W-1:0]    opcode_q;
  logic                 burst_busy;
  logic running, entering, leaving, any_active, sel_active, bad, exec;
  logic is_ref, sref_ok, rw_start, rw_write;

  sdram_cmd_decode u_decode (
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
    .ap   (addr[AP_BIT]), .cmd (raw_cmd)
  );

  assign running    = (mode_q == MODE_RUN) && cke;
  assign entering   = (mode_q == MODE_RUN) && !cke;
  assign leaving    = (mode_q != MODE_RUN) && cke;
  assign any_active = |bank_q;
  assign sel_active = bank_q[ba];
  assign is_ref     = (raw_cmd == CMD_REF);
  assign sref_ok    = entering && is_ref && !any_active;

  always_comb begin
    bad = 1'b0;
    case (raw_cmd)
      CMD_ACT:                           bad = sel_active;
      CMD_RD, CMD_RDA, CMD_WR, CMD_WRA:  bad = !sel_active;
      CMD_REF, CMD_MRS:                  bad = any_active;
      CMD_RSVD:                          bad = 1'b1;
      default:                           bad = 1'b0;
    endcase
    if (guard_q && raw_cmd != CMD_NOP && raw_cmd != CMD_DESEL) bad = 1'b1;
  end

  assign exec     = running && !bad;
  assign rw_write = (raw_cmd == CMD_WR) || (raw_cmd == CMD_WRA);
  assign rw_start = exec && (rw_write || raw_cmd == CMD_RD || raw_cmd == CMD_RDA);

  always_comb begin
    code_d = CMD_FROZEN;
    ill_d  = 1'b0;
    mode_d = mode_q;
    if (running) begin
      code_d = raw_cmd;
      ill_d  = bad;
    end else if (entering) begin
      if (is_ref) begin
        code_d = CMD_SREF;
        ill_d  = any_active;
      end
      if (sref_ok)                      mode_d = MODE_SELF;
      else if (any_active || burst_busy) mode_d = MODE_SUSPEND;
      else                              mode_d = MODE_PDOWN;
    end else if (leaving) begin
      mode_d = MODE_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RUN;
      guard_q  <= 1'b0;
      code_q   <= CMD_NOP;
      ill_q    <= 1'b0;
      opcode_q <= '0;
    end else begin
      mode_q  <= mode_d;
      guard_q <= leaving;
      code_q  <= code_d;
      ill_q   <= ill_d;
      if (exec && raw_cmd == CMD_MRS) opcode_q <= addr;
    end
  end

  sdram_bank_track #(.BA_W(BA_W)) u_banks (
    .clk (clk), .rst (rst), .exec (exec), .cmd (raw_cmd), .ba (ba),
    .active (bank_q)
  );

  sdram_dq_enables #(.DQM_W(DQM_W), .BURST_LEN(BURST_LEN)) u_dq (
    .clk (clk), .rst (rst), .run (running), .start (rw_start),
    .start_wr (rw_write), .dqm (dqm), .rd_oe (rd_oe_o), .wr_be (wr_be_o),
    .busy (burst_busy)
  );

  assign cmd_code_o    = code_q;
  assign cmd_illegal_o = ill_q;
  assign bank_active_o = bank_q;
  assign mode_o        = mode_q;
  assign mode_opcode_o = opcode_q;
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int BA_W  = 2,
  parameter int DQM_W = 2,
  localparam int NUM_BANKS = 1 << BA_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cke,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BA_W-1:0]      ba,
  input logic [1:0]           mode_q,
  input logic                 guard_q,
  input logic [NUM_BANKS-1:0] bank_q,
  input logic                 cmd_illegal_o,
  input logic [DQM_W-1:0]     rd_oe_o,
  input logic [DQM_W-1:0]     wr_be_o
);
  a_r10_bank_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 2'd0) |=> $stable(bank_q));

  a_r10_no_illegal_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 2'd0) |=> !cmd_illegal_o);

  a_r10_wrbe_zero: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 2'd0 || !cke) |=> (wr_be_o == '0));

  a_r10_rdoe_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 2'd0) |=> $stable(rd_oe_o));

  a_r9_guard_illegal: assert property (@(posedge clk) disable iff (rst)
    (guard_q && mode_q == 2'd0 && cke && !cs_n && !(ras_n && cas_n && we_n))
    |=> cmd_illegal_o);

  a_r7_no_pdown_active: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0 && !cke && |bank_q) |=> (mode_q != 2'd2));

  a_r4_act_active_illegal: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0 && cke && !cs_n && !ras_n && cas_n && we_n && bank_q[ba])
    |=> cmd_illegal_o);
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.BA_W(BA_W), .DQM_W(DQM_W)) u_chk (
  .clk (clk), .rst (rst), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
  .cas_n (cas_n), .we_n (we_n), .ba (ba), .mode_q (mode_q),
  .guard_q (guard_q), .bank_q (bank_q), .cmd_illegal_o (cmd_illegal_o),
  .rd_oe_o (rd_oe_o), .wr_be_o (wr_be_o)
);

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;
  localparam int AW = 13;
  localparam int DW = 2;
  localparam int BL = 4;

  logic clk = 1'b0;
  logic rst;
  logic cke, cs_n, ras_n, cas_n, we_n;
  logic [DW-1:0] dqm;
  logic [1:0]    ba;
  logic [AW-1:0] addr;
  logic [3:0]    cmd_code_o;
  logic          cmd_illegal_o;
  logic [3:0]    bank_active_o;
  logic [1:0]    mode_o;
  logic [DW-1:0] rd_oe_o, wr_be_o;
  logic [AW-1:0] mode_opcode_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_cmd_monitor #(.ADDR_W(AW), .BA_W(2), .DQM_W(DW), .BURST_LEN(BL)) i_sdram_cmd_monitor (
    .clk (clk), .rst (rst), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .dqm (dqm), .ba (ba), .addr (addr),
    .cmd_code_o (cmd_code_o), .cmd_illegal_o (cmd_illegal_o),
    .bank_active_o (bank_active_o), .mode_o (mode_o), .rd_oe_o (rd_oe_o),
    .wr_be_o (wr_be_o), .mode_opcode_o (mode_opcode_o)
  );

  // reference model state, built from the requirement text
  int            m_mode, m_cnt;
  bit            m_guard, m_wr, m_sbeat;
  logic [DW-1:0] m_sdqm;
  logic [3:0]    m_bank;
  int            e_code;
  bit            e_ill;
  logic [DW-1:0] e_rdoe, e_wrbe;
  logic [AW-1:0] e_op;

  task automatic model_reset();
    m_mode = 0; m_cnt = 0; m_guard = 0; m_wr = 0; m_sbeat = 0; m_sdqm = '0;
    m_bank = '0; e_code = 1; e_ill = 0; e_rdoe = '0; e_wrbe = '0; e_op = '0;
  endtask

  task automatic model_step();
    int  raw;
    bit  run, ent, lv, anya, sel, bad, start, swr, beat, bwr, busy;
    raw = 0;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b111: raw = 1;
        3'b011: raw = 2;
        3'b101: raw = addr[10] ? 4 : 3;
        3'b100: raw = addr[10] ? 6 : 5;
        3'b010: raw = addr[10] ? 8 : 7;
        3'b001: raw = 9;
        3'b000: raw = 11;
        default: raw = 12;
      endcase
    end
    run  = (m_mode == 0) && cke;
    ent  = (m_mode == 0) && !cke;
    lv   = (m_mode != 0) && cke;
    anya = |m_bank;
    sel  = m_bank[ba];
    busy = (m_cnt != 0);
    bad  = 0;
    if (raw == 2) bad = sel;
    if (raw >= 3 && raw <= 6) bad = !sel;
    if (raw == 9 || raw == 11) bad = anya;
    if (raw == 12) bad = 1;
    if (m_guard && raw > 1) bad = 1;
    start = run && !bad && raw >= 3 && raw <= 6;
    swr   = (raw == 5 || raw == 6);
    e_code = 13; e_ill = 0;
    if (run) begin
      e_code = raw; e_ill = bad;
      if (!bad) begin
        if (raw == 2) m_bank[ba] = 1'b1;
        if (raw == 4 || raw == 6 || raw == 7) m_bank[ba] = 1'b0;
        if (raw == 8) m_bank = '0;
        if (raw == 11) e_op = addr;
      end
      beat = start || busy;
      bwr  = start ? swr : m_wr;
      m_cnt = start ? BL - 1 : (busy ? m_cnt - 1 : 0);
      m_wr  = bwr;
      e_wrbe = (beat && bwr) ? ~dqm : '0;
      e_rdoe = m_sbeat ? ~m_sdqm : '0;
      m_sbeat = beat && !bwr;
      m_sdqm  = dqm;
      m_guard = 0;
    end else begin
      e_wrbe = '0;
      if (ent) begin
        if (raw == 9) begin e_code = 10; e_ill = anya; end
        if (raw == 9 && !anya) m_mode = 3;
        else if (anya || busy) m_mode = 1;
        else m_mode = 2;
        m_guard = 0;
      end else if (lv) begin
        m_mode = 0; m_guard = 1;
      end
    end
  endtask

  task automatic chk(input string tag, input string fld, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, fld, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "cmd_code(R1)", int'(cmd_code_o), e_code);
    chk(tag, "illegal(R4)", int'(cmd_illegal_o), int'(e_ill));
    chk(tag, "banks(R2)", int'(bank_active_o), int'(m_bank));
    chk(tag, "mode(R7)", int'(mode_o), m_mode);
    chk(tag, "rd_oe(R12)", int'(rd_oe_o), int'(e_rdoe));
    chk(tag, "wr_be(R11)", int'(wr_be_o), int'(e_wrbe));
    chk(tag, "opcode(R5)", int'(mode_opcode_o), int'(e_op));
  endtask

  // drive at the falling edge, predict, then compare at the next falling edge
  task automatic cyc(input logic cs, input logic [2:0] rcw, input logic ck,
                     input logic [1:0] b, input logic [AW-1:0] a,
                     input logic [DW-1:0] dm, input string tag);
    cs_n = cs; {ras_n, cas_n, we_n} = rcw; cke = ck; ba = b; addr = a; dqm = dm;
    model_step();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic nop(input logic ck, input logic [DW-1:0] dm, input string tag);
    cyc(1'b0, 3'b111, ck, 2'b00, '0, dm, tag);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst = 1'b1; cke = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111;
    ba = '0; addr = '0; dqm = '0;
    repeat (3) @(negedge clk);
    model_reset();
    check_all("R13");
    rst = 1'b0;

    // R2: ba[0] alone picks bank 1, ba[1] alone picks bank 2
    cyc(0, 3'b011, 1, 2'b01, 13'h0, 2'b00, "R2");
    cyc(0, 3'b011, 1, 2'b10, 13'h0, 2'b00, "R2");
    // R4: activate to open bank, read to closed bank, reserved
    cyc(0, 3'b011, 1, 2'b01, 13'h0, 2'b00, "R4");
    cyc(0, 3'b101, 1, 2'b00, 13'h0, 2'b00, "R4");
    cyc(0, 3'b110, 1, 2'b00, 13'h0, 2'b00, "R4");
    // R11: write burst with mask changing per beat
    cyc(0, 3'b100, 1, 2'b01, 13'h0, 2'b01, "R11");
    nop(1, 2'b10, "R11"); nop(1, 2'b11, "R11"); nop(1, 2'b00, "R11");
    nop(1, 2'b01, "R11");
    // R12: read burst, mask effect two clocks later
    cyc(0, 3'b101, 1, 2'b10, 13'h0, 2'b10, "R12");
    nop(1, 2'b01, "R12"); nop(1, 2'b11, "R12"); nop(1, 2'b00, "R12");
    nop(1, 2'b00, "R12"); nop(1, 2'b00, "R12");
    // R5: refresh and mode set with open rows are illegal
    cyc(0, 3'b001, 1, 2'b00, 13'h0, 2'b00, "R5");
    cyc(0, 3'b000, 1, 2'b00, 13'h0ABC, 2'b00, "R5");
    // R3: single precharge then precharge all
    cyc(0, 3'b010, 1, 2'b01, 13'h0, 2'b00, "R3");
    cyc(0, 3'b010, 1, 2'b00, 13'h0400, 2'b00, "R3");
    cyc(0, 3'b000, 1, 2'b00, 13'h1A5C, 2'b00, "R5");
    cyc(0, 3'b001, 1, 2'b00, 13'h0, 2'b00, "R5");
    // R7: auto-precharge read closes bank, burst still runs -> suspend
    cyc(0, 3'b011, 1, 2'b11, 13'h0, 2'b00, "R3");
    cyc(0, 3'b101, 1, 2'b11, 13'h0400, 2'b00, "R3");
    nop(0, 2'b11, "R7");
    // R10: garbage while suspended
    cyc(0, 3'b011, 0, 2'b00, 13'h0, 2'b01, "R10");
    cyc(0, 3'b100, 0, 2'b00, 13'h0, 2'b10, "R10");
    // R8 exit then R9 guard violation
    nop(1, 2'b00, "R8");
    cyc(0, 3'b011, 1, 2'b00, 13'h0, 2'b00, "R9");
    repeat (BL) nop(1, 2'b00, "R11");
    // R7: power down with everything idle
    nop(0, 2'b00, "R7");
    nop(0, 2'b00, "R10");
    cyc(1, 3'b000, 1, 2'b00, 13'h0, 2'b00, "R8");
    cyc(1, 3'b000, 1, 2'b00, 13'h0, 2'b00, "R9");
    // R6: self refresh entry legal, then illegal with a row open
    cyc(0, 3'b001, 0, 2'b00, 13'h0, 2'b00, "R6");
    nop(0, 2'b00, "R10"); nop(0, 2'b00, "R10");
    nop(1, 2'b00, "R8"); nop(1, 2'b00, "R9");
    cyc(0, 3'b011, 1, 2'b00, 13'h0, 2'b00, "R6");
    cyc(0, 3'b001, 0, 2'b00, 13'h0, 2'b00, "R6");
    nop(1, 2'b00, "R8"); nop(1, 2'b00, "R9");

    // R1: constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic ck;
      if (m_mode == 0) ck = (($urandom % 16) != 0);
      else             ck = (($urandom % 3) == 0);
      cyc(($urandom % 10) == 0, 3'($urandom % 8), ck, 2'($urandom % 4),
          AW'($urandom), DW'($urandom), "R1");
    end

    rst = 1'b1;
    @(negedge clk);
    model_reset();
    check_all("R13");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule